// File: doc/BRIEF.md
# Dual Recursive Sine Tone Generator

This block makes the tone signal for one voice channel. It holds two sine oscillators. Each oscillator is a second-order digital resonator that advances once per sample strobe. The strobe is expected at 8 kHz. The two tone values are added, clipped to the signed 16-bit range and presented as one output sample, together with a one-cycle valid pulse.

Each oscillator has two coefficients. The first is a Q15 frequency coefficient, c = 32767·cos(2π·f/8000). The second is a Q15 amplitude coefficient, a = A·32767·sin(2π·f/8000), with A between 0 and 1. Both are loaded through a small write port. When an oscillator is switched on, its state starts at y[-1] = 0 and y[-2] = -a. Its output therefore starts at a, and its peak level is linear in A. From then on it follows the recurrence y[n] = round(2·c·y[n-1] / 2^15) - y[n-2]. An oscillator that is switched off gives zero. The intended tone range is 25 Hz to 3400 Hz.

Top module: `tone_pair_gen`

## Requirements
- R1: While the reset is applied and after it is released, `sample` reads 0 and `sample_vld` reads 0 until the first sample strobe.
- R2: `sample_vld` is high for exactly the one clock that follows each clock in which `smp_stb` is high, and it is low at all other times.
- R3: At the first strobe that sees `en[g]` high after it was low, oscillator g outputs its stored amplitude coefficient a. This is the result of the start state y[-1]=0, y[-2]=-a. With the other oscillator off, `sample` equals a.
- R4: At each later strobe with `en[g]` still high, oscillator g outputs y = ((2·c·y1 + 16384) >>> 15) - y2, clipped to [-32768, 32767]. Here y1 and y2 are its two previous outputs and c is its latched frequency coefficient.
- R5: At a strobe where `en[g]` is low, oscillator g contributes 0. With both oscillators off, `sample` is 0. The next enable of that oscillator restarts it as in R3.
- R6: `sample` is the sum of the two oscillator outputs, saturated to 32767 above and to -32768 below.
- R7: A write with `wr_en` high stores `wr_freq` and `wr_amp` for the oscillator selected by `wr_sel` (0 selects oscillator 0, 1 selects oscillator 1). An oscillator that is running keeps its latched coefficients. New values take effect only at its next enable.
- R8: `en` is sampled only at strobes. `sample` holds its value in every clock that does not follow a strobe, whatever `en` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-clock sample strobe (8 kHz) |
| en | input | 2 | Per-oscillator enable, bit g for oscillator g |
| wr_en | input | 1 | Coefficient write strobe |
| wr_sel | input | 1 | Oscillator selected by the write |
| wr_freq | input | 16 | Q15 frequency coefficient to store |
| wr_amp | input | 16 | Q15 amplitude coefficient to store |
| sample | output | 16 | Signed summed tone sample |
| sample_vld | output | 1 | High for one clock after each strobe |

## Verification
Every result is due exactly one clock after the strobe that produces it. This covers the new sample value and the valid pulse. The bench raises the strobe on a falling edge and checks both at the next falling edge. It then checks at the falling edge after that, where the valid pulse must be low again and the sample unchanged. Coefficient writes and enable changes are applied between strobes. Their effect is checked only at the following strobe's result, against a bench model of the recurrence. For the write-while-running case, that model keeps the coefficients latched at each enable.

// File: rtl/tone_pkg.sv
package tone_pkg;
  parameter int SMP_W = 16;
  parameter int N_GEN = 2;
endpackage

// File: rtl/tone_rst_sync.sv
module tone_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/tone_coef_regs.sv
module tone_coef_regs #(
  parameter int W    = 16,
  parameter int NGEN = 2,
  parameter int SELW = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SELW-1:0]          wr_sel,
  input  logic [W-1:0]             wr_freq,
  input  logic [W-1:0]             wr_amp,
  output logic [NGEN-1:0][W-1:0]   freq_o,
  output logic [NGEN-1:0][W-1:0]   amp_o
);
  for (genvar g = 0; g < NGEN; g++) begin : g_slot
    logic           hit;
    logic [W-1:0]   f_d, a_d;

    assign hit = wr_en && (wr_sel == SELW'(g));

    always_comb begin
      f_d = freq_o[g];
      a_d = amp_o[g];
      if (hit) begin
        f_d = wr_freq;
        a_d = wr_amp;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        freq_o[g] <= '0;
        amp_o[g]  <= '0;
      end else begin
        freq_o[g] <= f_d;
        amp_o[g]  <= a_d;
      end
    end
  end
endmodule

// File: rtl/tone_resonator.sv
module tone_resonator #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stb,
  input  logic                en,
  input  logic signed [W-1:0] c_in,
  input  logic signed [W-1:0] a_in,
  output logic signed [W-1:0] y_now
);
  localparam int PW = 2*W + 1;
  localparam int SH = W - 2;
  localparam logic signed [PW-1:0] BIAS = PW'(1) <<< (SH - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((2**(W-1)) - 1);
  localparam logic signed [PW-1:0] MINV = -(PW'(2**(W-1)));

  logic signed [W-1:0]  c_q, y1_q, y2_q, c_d, y1_d, y2_d;
  logic                 run_q, run_d;
  logic signed [PW-1:0] prod, rnd, diff;
  logic signed [W-1:0]  y_rec;

  // 2*c*y1 / 2^15 with rounding equals (c*y1 + 2^13) >>> 14
  always_comb begin
    prod = PW'(c_q) * PW'(y1_q);
    rnd  = (prod + BIAS) >>> SH;
    diff = rnd - PW'(y2_q);
    if (diff > MAXV)      y_rec = MAXV[W-1:0];
    else if (diff < MINV) y_rec = MINV[W-1:0];
    else                  y_rec = diff[W-1:0];
  end

  always_comb begin
    if (!en)        y_now = '0;
    else if (!run_q) y_now = a_in;
    else            y_now = y_rec;
  end

  always_comb begin
    run_d = run_q;
    c_d   = c_q;
    y1_d  = y1_q;
    y2_d  = y2_q;
    if (stb) begin
      run_d = en;
      if (en && !run_q) begin
        c_d  = c_in;
        y1_d = a_in;
        y2_d = '0;
      end else if (en) begin
        y1_d = y_rec;
        y2_d = y1_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      c_q   <= '0;
      y1_q  <= '0;
      y2_q  <= '0;
    end else begin
      run_q <= run_d;
      c_q   <= c_d;
      y1_q  <= y1_d;
      y2_q  <= y2_d;
    end
  end
endmodule

// File: rtl/tone_mixer.sv
module tone_mixer #(
  parameter int W    = 16,
  parameter int NGEN = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stb,
  input  logic [NGEN-1:0][W-1:0] tones,
  output logic signed [W-1:0]    sample,
  output logic                   sample_vld
);
  localparam int SW = W + $clog2(NGEN) + 1;
  localparam logic signed [SW-1:0] MAXV = SW'((2**(W-1)) - 1);
  localparam logic signed [SW-1:0] MINV = -(SW'(2**(W-1)));

  logic signed [SW-1:0] acc;
  logic signed [W-1:0]  sat, sample_d;
  logic                 vld_d;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NGEN; i++) acc = acc + SW'($signed(tones[i]));
    if (acc > MAXV)      sat = MAXV[W-1:0];
    else if (acc < MINV) sat = MINV[W-1:0];
    else                 sat = acc[W-1:0];
  end

  always_comb begin
    vld_d    = stb;
    sample_d = stb ? sat : sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample     <= '0;
      sample_vld <= 1'b0;
    end else begin
      sample     <= sample_d;
      sample_vld <= vld_d;
    end
  end
endmodule

// File: rtl/tone_pair_gen.sv
module tone_pair_gen #(
  parameter int W    = tone_pkg::SMP_W,
  parameter int NGEN = tone_pkg::N_GEN,
  localparam int SELW = (NGEN > 1) ? $clog2(NGEN) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_stb,
  input  logic [NGEN-1:0]     en,
  input  logic                wr_en,
  input  logic [SELW-1:0]     wr_sel,
  input  logic [W-1:0]        wr_freq,
  input  logic [W-1:0]        wr_amp,
  output logic signed [W-1:0] sample,
  output logic                sample_vld
);
  logic                   rst_n_s;
  logic [NGEN-1:0][W-1:0] freq_r, amp_r, tone_v;

  tone_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  tone_coef_regs #(.W(W), .NGEN(NGEN), .SELW(SELW)) u_coef (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_freq (wr_freq),
    .wr_amp  (wr_amp),
    .freq_o  (freq_r),
    .amp_o   (amp_r)
  );

  for (genvar g = 0; g < NGEN; g++) begin : g_osc
    logic signed [W-1:0] y_g;

    tone_resonator #(.W(W)) u_res (
      .clk   (clk),
      .rst_n (rst_n_s),
      .stb   (smp_stb),
      .en    (en[g]),
      .c_in  ($signed(freq_r[g])),
      .a_in  ($signed(amp_r[g])),
      .y_now (y_g)
    );

    assign tone_v[g] = y_g;
  end

  tone_mixer #(.W(W), .NGEN(NGEN)) u_mix (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .stb        (smp_stb),
    .tones      (tone_v),
    .sample     (sample),
    .sample_vld (sample_vld)
  );
endmodule

// File: rtl/tone_pair_chk.sv
module tone_pair_chk #(
  parameter int W    = 16,
  parameter int NGEN = 2,
  parameter int SELW = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_stb,
  input logic [NGEN-1:0]     en,
  input logic                wr_en,
  input logic [SELW-1:0]     wr_sel,
  input logic [W-1:0]        wr_amp,
  input logic signed [W-1:0] sample,
  input logic                sample_vld
);
  logic [NGEN-1:0] prev_en;
  logic [W-1:0]    amp0_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en <= '0;
      amp0_sh <= '0;
    end else begin
      if (smp_stb) prev_en <= en;
      if (wr_en && wr_sel == '0) amp0_sh <= wr_amp;
    end
  end

  assert_vld_after_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> sample_vld);

  assert_vld_only_after_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> !sample_vld);

  assert_start_amp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && en == NGEN'(1) && prev_en == '0) |=> (sample == $signed($past(amp0_sh))));

  assert_off_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && en == '0) |=> (sample == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(sample));
endmodule

bind tone_pair_gen tone_pair_chk #(.W(W), .NGEN(NGEN), .SELW(SELW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_stb    (smp_stb),
  .en         (en),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_amp     (wr_amp),
  .sample     (sample),
  .sample_vld (sample_vld)
);

// File: tb/sim_tone_pair_gen.sv
`timescale 1ns/1ps
module sim_tone_pair_gen;
  logic               clk;
  logic               rst_n;
  logic               smp_stb;
  logic [1:0]         en;
  logic               wr_en;
  logic [0:0]         wr_sel;
  logic [15:0]        wr_freq;
  logic [15:0]        wr_amp;
  logic signed [15:0] sample;
  logic               sample_vld;

  int n_chk;
  int n_err;
  bit done;

  longint m_c[2], m_a[2], m_cact[2], m_y1[2], m_y2[2];
  bit     m_run[2];

  tone_pair_gen u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .en(en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_freq(wr_freq), .wr_amp(wr_amp),
    .sample(sample), .sample_vld(sample_vld)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint clip(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_step(output longint exp);
    longint s, y, p;
    s = 0;
    for (int g = 0; g < 2; g++) begin
      if (en[g]) begin
        if (!m_run[g]) begin
          m_cact[g] = m_c[g];
          y = m_a[g];
          m_y2[g] = 0;
          m_y1[g] = y;
        end else begin
          p = 2 * m_cact[g] * m_y1[g];
          y = clip(((p + 16384) >>> 15) - m_y2[g]);
          m_y2[g] = m_y1[g];
          m_y1[g] = y;
        end
        m_run[g] = 1'b1;
        s += y;
      end else begin
        m_run[g] = 1'b0;
      end
    end
    exp = clip(s);
  endtask

  task automatic strobe(input string req, output longint got);
    longint exp, held;
    model_step(exp);
    @(negedge clk);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    check("R2 valid after strobe", longint'(sample_vld), 1);
    got = longint'(sample);
    check(req, got, exp);
    held = longint'(sample);
    @(negedge clk);
    check("R2 valid single cycle", longint'(sample_vld), 0);
    check("R8 sample held", longint'(sample), held);
  endtask

  task automatic write_coef(input int g, input longint c, input longint a);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'(g); wr_freq = 16'(c); wr_amp = 16'(a);
    @(negedge clk);
    wr_en = 1'b0;
    m_c[g] = c;
    m_a[g] = a;
  endtask

  task automatic t_reset;
    check("R1 sample after reset", longint'(sample), 0);
    check("R1 valid after reset", longint'(sample_vld), 0);
  endtask

  task automatic t_quarter;
    longint got;
    write_coef(0, 0, 1000);
    en = 2'b01;
    strobe("R3 first sample is amplitude", got);
    check("R3 first value", got, 1000);
    for (int k = 0; k < 6; k++) strobe("R4 quarter-rate sequence", got);
  endtask

  task automatic t_recur;
    longint got;
    en = 2'b00;
    strobe("R5 both off silent", got);
    check("R5 silence", got, 0);
    write_coef(1, 23170, 12000);
    en = 2'b10;
    strobe("R3 restart osc1", got);
    check("R3 osc1 first value", got, 12000);
    for (int k = 0; k < 24; k++) strobe("R4 1 kHz recurrence", got);
  endtask

  task automatic t_reenable;
    longint got;
    en = 2'b00;
    strobe("R5 off contributes zero", got);
    check("R5 zero after disable", got, 0);
    en = 2'b10;
    strobe("R5 reenable restarts", got);
    check("R5 restart value", got, 12000);
  endtask

  task automatic t_dual;
    longint got;
    en = 2'b00;
    strobe("R5 gap", got);
    write_coef(0, 16384, 8000);
    write_coef(1, 30274, 5000);
    en = 2'b11;
    strobe("R6 dual first", got);
    check("R6 dual first sum", got, 13000);
    for (int k = 0; k < 16; k++) strobe("R6 dual tone sum", got);
  endtask

  task automatic t_saturate;
    longint got;
    en = 2'b00;
    strobe("R5 gap", got);
    write_coef(0, 0, 30000);
    write_coef(1, 0, 30000);
    en = 2'b11;
    strobe("R6 positive clip", got);
    check("R6 clip high", got, 32767);
    strobe("R6 zero crossing", got);
    check("R6 mid", got, 0);
    strobe("R6 negative clip", got);
    check("R6 clip low", got, -32768);
  endtask

  task automatic t_write_running;
    longint got;
    en = 2'b00;
    strobe("R5 gap", got);
    write_coef(0, 0, 1000);
    en = 2'b01;
    strobe("R7 start", got);
    write_coef(0, 16384, 2000);
    strobe("R7 running keeps old c", got);
    check("R7 old frequency kept", got, 0);
    strobe("R7 running keeps old c", got);
    check("R7 old sequence", got, -1000);
    en = 2'b00;
    strobe("R5 gap", got);
    en = 2'b01;
    strobe("R7 new coefficients at enable", got);
    check("R7 new amplitude", got, 2000);
  endtask

  task automatic t_hold;
    longint got, held;
    strobe("R8 reference", got);
    held = got;
    en = 2'b10;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 stable without strobe", longint'(sample), held);
      check("R2 no valid without strobe", longint'(sample_vld), 0);
    end
    en = 2'b01;
    strobe("R8 en sampled only at strobe", got);
  endtask

  initial begin
    done = 1'b0;
    #150000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; smp_stb = 1'b0; en = 2'b00;
    wr_en = 1'b0; wr_sel = '0; wr_freq = '0; wr_amp = '0;
    for (int g = 0; g < 2; g++) begin
      m_c[g] = 0; m_a[g] = 0; m_cact[g] = 0; m_y1[g] = 0; m_y2[g] = 0; m_run[g] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1 sample in reset", longint'(sample), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_quarter();
    t_recur();
    t_reenable();
    t_dual();
    t_saturate();
    t_write_running();
    t_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule